// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Target Table and Return Stack

This block sits in the fetch stage and guesses the address that follows each fetched instruction. Every fetch address is looked up in a small direct-mapped table of tagged entries, whether or not the instruction turns out to be a branch. A tag hit marks the instruction as a control transfer before it is decoded, and the stored target becomes the guess. When the fetch address misses, the guess is the next sequential word.

Function returns get their targets from a separate last-in first-out stack of return addresses. A table entry can carry a return flag. On a hit to such an entry, the guess is the address on top of the stack instead of the stored target. Later stages send in corrections: a taken branch with its real target, a call that pushes its return address, and a return that pops one. The prediction is combinational on the fetch address. Corrections are registered, and the first fetch that sees them is the one in the next cycle.

Top module: `bpred_next_pc`

## Requirements
- R1: While reset is high and in the first cycle after it, no fetch address hits. Reset clears every table valid bit, sets the stack pointer to zero and sets every stack slot to zero.
- R2: If the fetch address misses, `pred_hit` is 0 and `pred_next_pc` is `fetch_pc + 4`.
- R3: The table slot is chosen by fetch address bits [5:2] (default 16 slots). The tag is bits [31:6]. Two addresses that share bits [5:2] but differ above them do not hit on each other's entry.
- R4: After an update with `upd_valid` = 1 and `upd_is_ret` = 0, a fetch of `upd_pc` in any later cycle hits and predicts `upd_target`, until that slot is written again.
- R5: An update to an address that shares a slot with an existing entry replaces that entry. The old address then misses.
- R6: `call_push` alone writes `call_pc + 4` into the slot at the pointer, then increments the pointer. A fetch that hits an entry written with `upd_is_ret` = 1 predicts the slot just below the pointer.
- R7: `ret_pop` alone decrements the pointer. The slot the pointer now points to is no longer the top, so nested calls are returned in LIFO order.
- R8: The pointer wraps modulo the stack depth (default 8). A ninth push with no pops in between overwrites the oldest slot.
- R9: When `call_push` and `ret_pop` are both high in one cycle, the pointer is unchanged and the current top slot is overwritten with `call_pc + 4`.
- R10: A pop at pointer zero wraps the pointer to depth-1. The top then reads whatever that slot holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted address of the next fetch |
| pred_hit | output | 1 | Fetch address matched a valid table entry |
| upd_valid | input | 1 | Taken-branch correction present |
| upd_pc | input | 32 | Address of the taken branch |
| upd_target | input | 32 | Resolved target of the taken branch |
| upd_is_ret | input | 1 | The corrected branch is a return |
| call_push | input | 1 | A call was seen; push its return address |
| call_pc | input | 32 | Address of that call |
| ret_pop | input | 1 | A return was seen; pop the stack |

## Verification
The assertions assume that the control inputs are never unknown and that the stack depth is a power of two, so the pointer wraps without further logic. They also assume that a push value presented in a cycle is meant to become the top of the stack in the next cycle. The stimulus keeps every address word aligned. It draws tags from only three values, so slot aliasing, replacement and repeated hits occur often. It raises push and pop independently, which produces overflow, underflow and the push-with-pop case during random runs. Directed sequences set each of these cases up on purpose as well.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    localparam int PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;

    // outcome of one table lookup
    typedef struct packed {
        logic hit;
        logic is_ret;
        pc_t  target;
    } lookup_t;

    // stack operation decoded from the two strobes
    typedef enum logic [1:0] {
        STK_IDLE = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_SWAP = 2'b11
    } stk_op_e;

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(4);
    endfunction

    function automatic stk_op_e stk_decode(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  pc_t     look_pc,
    output lookup_t look_res,
    input  logic    wr_en,
    input  pc_t     wr_pc,
    input  pc_t     wr_target,
    input  logic    wr_is_ret
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic valid;
        logic is_ret;
        tag_t tag;
        pc_t  target;
    } slot_t;

    slot_t tbl_q [ENTRIES];
    logic  writes_seen_q;

    idx_t  look_idx, wr_idx;
    tag_t  look_tag, wr_tag;
    slot_t look_slot, wr_slot;
    logic  wr_same, wr_do;

    always_comb begin
        look_idx  = look_pc[IDX_W+1:2];
        look_tag  = look_pc[PC_W-1:IDX_W+2];
        look_slot = tbl_q[look_idx];
        look_res.hit    = look_slot.valid && (look_slot.tag == look_tag);
        look_res.is_ret = look_slot.is_ret;
        look_res.target = look_slot.target;
    end

    // only write when the stored guess would have been wrong
    always_comb begin
        wr_idx  = wr_pc[IDX_W+1:2];
        wr_tag  = wr_pc[PC_W-1:IDX_W+2];
        wr_slot = tbl_q[wr_idx];
        wr_same = wr_slot.valid && (wr_slot.tag == wr_tag)
                  && (wr_slot.target == wr_target) && (wr_slot.is_ret == wr_is_ret);
        wr_do   = wr_en && !wr_same;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i].valid <= 1'b0;
            end
            writes_seen_q <= 1'b0;
        end else begin
            if (wr_do) begin
                tbl_q[wr_idx] <= '{valid: 1'b1, is_ret: wr_is_ret, tag: wr_tag, target: wr_target};
            end
            if (wr_en) begin
                writes_seen_q <= 1'b1;
            end
        end
    end

    // R1
    no_hit_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        !writes_seen_q |-> !look_res.hit);

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl_q[$past(wr_idx)].valid && tbl_q[$past(wr_idx)].tag == $past(wr_tag)
                   && tbl_q[$past(wr_idx)].target == $past(wr_target)));

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras
    import bpred_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pc_t  push_val,
    input  logic pop,
    output pc_t  top
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t PTR_ONE = ptr_t'(1);

    pc_t     slot_q [DEPTH];
    ptr_t    ptr_q;
    ptr_t    below;
    stk_op_e op;

    always_comb begin
        below = ptr_q - PTR_ONE;
        top   = slot_q[below];
        op    = stk_decode(push, pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            unique case (op)
                STK_PUSH: begin
                    slot_q[ptr_q] <= push_val;
                    ptr_q         <= ptr_q + PTR_ONE;
                end
                STK_POP: begin
                    ptr_q <= below;
                end
                STK_SWAP: begin
                    slot_q[below] <= push_val;
                end
                default: ;
            endcase
        end
    end

    // R6
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> top == $past(push_val));

    // R8
    ptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> ptr_q == ptr_t'($past(ptr_q) + PTR_ONE));

    // R7
    ptr_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ptr_q == ptr_t'($past(ptr_q) - PTR_ONE));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && push) |=> $stable(ptr_q));

endmodule

// File: rtl/bpred_next_pc.sv
module bpred_next_pc
    import bpred_pkg::*;
#(
    parameter int BTB_ENTRIES = 16,
    parameter int RAS_DEPTH   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_pc,
    output logic [31:0] pred_next_pc,
    output logic        pred_hit,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic [31:0] upd_target,
    input  logic        upd_is_ret,
    input  logic        call_push,
    input  logic [31:0] call_pc,
    input  logic        ret_pop
);
    lookup_t res;
    pc_t     ras_top;

    bpred_btb #(.ENTRIES(BTB_ENTRIES)) u_btb (
        .clk       (clk),
        .rst       (rst),
        .look_pc   (fetch_pc),
        .look_res  (res),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_target (upd_target),
        .wr_is_ret (upd_is_ret)
    );

    bpred_ras #(.DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst      (rst),
        .push     (call_push),
        .push_val (seq_pc(call_pc)),
        .pop      (ret_pop),
        .top      (ras_top)
    );

    always_comb begin
        pred_hit = res.hit;
        if (!res.hit)        pred_next_pc = seq_pc(fetch_pc);
        else if (res.is_ret) pred_next_pc = ras_top;
        else                 pred_next_pc = res.target;
    end

endmodule

// File: tb/bpred_next_pc_bench.sv
module bpred_next_pc_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, pred_next_pc, upd_pc, upd_target, call_pc;
    logic        pred_hit, upd_valid, upd_is_ret, call_push, ret_pop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bpred_next_pc u_bpred_next_pc (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
        .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_is_ret(upd_is_ret), .call_push(call_push),
        .call_pc(call_pc), .ret_pop(ret_pop)
    );

    // reference state built from the requirements
    bit          m_valid [16];
    bit          m_ret   [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_tgt   [16];
    logic [31:0] m_stk   [8];
    logic [2:0]  m_ptr;

    function automatic bit m_hit(input logic [31:0] pc);
        return m_valid[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
    endfunction

    function automatic logic [31:0] m_next(input logic [31:0] pc);
        if (!m_hit(pc)) return pc + 32'd4;
        if (m_ret[pc[5:2]]) return m_stk[m_ptr - 3'd1];
        return m_tgt[pc[5:2]];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
        for (int i = 0; i < 8; i++)  m_stk[i] = '0;
        m_ptr = '0;
    endtask

    task automatic m_clock();
        if (upd_valid) begin
            m_valid[upd_pc[5:2]] = 1'b1;
            m_ret[upd_pc[5:2]]   = upd_is_ret;
            m_tag[upd_pc[5:2]]   = upd_pc[31:6];
            m_tgt[upd_pc[5:2]]   = upd_target;
        end
        if (call_push && ret_pop) m_stk[m_ptr - 3'd1] = call_pc + 32'd4;
        else if (call_push) begin
            m_stk[m_ptr] = call_pc + 32'd4;
            m_ptr = m_ptr + 3'd1;
        end else if (ret_pop) m_ptr = m_ptr - 3'd1;
    endtask

    task automatic check(input string req);
        checks++;
        if (pred_hit !== m_hit(fetch_pc) || pred_next_pc !== m_next(fetch_pc)) begin
            fails++;
            $display("FAIL %s pc=%h hit=%b next=%h expected hit=%b next=%h", req, fetch_pc,
                     pred_hit, pred_next_pc, m_hit(fetch_pc), m_next(fetch_pc));
        end
    endtask

    // drive after negedge, sample 1 time unit later, then advance a clock
    task automatic step(input string req, input logic [31:0] fpc,
                        input bit uv, input logic [31:0] upc, input logic [31:0] utgt,
                        input bit uret, input bit psh, input logic [31:0] cpc, input bit pp);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_target = utgt;
        upd_is_ret = uret; call_push = psh; call_pc = cpc; ret_pop = pp;
        #1;
        check(req);
        @(posedge clk);
        m_clock();
        @(negedge clk);
    endtask

    task automatic look(input string req, input logic [31:0] fpc);
        step(req, fpc, 0, '0, '0, 0, 0, '0, 0);
    endtask

    function automatic logic [31:0] rpc();
        return {24'h0, 2'($urandom % 3), 4'($urandom), 2'b00};
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        fetch_pc = 32'h100; upd_valid = 0; upd_pc = '0; upd_target = '0;
        upd_is_ret = 0; call_push = 0; call_pc = '0; ret_pop = 0;
        m_reset();
        @(negedge clk); @(negedge clk);
        #1 check("R1");
        rst = 1'b0;
        look("R1", 32'h0000_0100);
        look("R2", 32'h0000_1234 & ~32'h3);

        // R4 taken update then hit
        step("R4", 32'h0000_0040, 1, 32'h0000_1040, 32'h0000_2000, 0, 0, '0, 0);
        look("R4", 32'h0000_1040);
        // R3 alias with same index, different tag
        look("R3", 32'h0000_1080);
        // R5 replacement
        step("R5", 32'h0, 1, 32'h0000_1080, 32'h0000_3000, 0, 0, '0, 0);
        look("R5", 32'h0000_1040);
        look("R5", 32'h0000_1080);

        // R6 return entry at 0x500, then pushes
        step("R6", 32'h0, 1, 32'h0000_0500, 32'h0000_dead, 1, 1, 32'h0000_0700, 0);
        look("R6", 32'h0000_0500);
        step("R7", 32'h0000_0500, 0, '0, '0, 0, 1, 32'h0000_0800, 0);
        look("R7", 32'h0000_0500);
        step("R7", 32'h0000_0500, 0, '0, '0, 0, 0, '0, 1);
        look("R7", 32'h0000_0500);
        // R9 push and pop together
        step("R9", 32'h0000_0500, 0, '0, '0, 0, 1, 32'h0000_0900, 1);
        look("R9", 32'h0000_0500);

        // R8 overflow: nine pushes then pops past the bottom
        for (int i = 0; i < 9; i++)
            step("R8", 32'h0000_0500, 0, '0, '0, 0, 1, 32'h0001_0000 + 32'(i * 16), 0);
        for (int i = 0; i < 8; i++)
            step("R8", 32'h0000_0500, 0, '0, '0, 0, 0, '0, 1);
        // R10 underflow wraps
        for (int i = 0; i < 4; i++)
            step("R10", 32'h0000_0500, 0, '0, '0, 0, 0, '0, 1);
        look("R10", 32'h0000_0500);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f;
            string tag;
            f = rpc();
            tag = !m_hit(f) ? "R2" : (m_ret[f[5:2]] ? "R6" : "R4");
            step(tag, f, ($urandom % 10) < 3, rpc(), {$urandom} & ~32'h3,
                 ($urandom % 5) == 0, ($urandom % 7) == 0, rpc(), ($urandom % 7) == 0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule